// File: doc/BRIEF.md
# Prefix-Extended Immediate Operand Mux

This block forms the second (B) operand of a processor whose instructions are a fixed 16 bits wide. For each instruction it selects among a value read from the register file, the 4-bit immediate in the low nibble of the instruction, and a left-justified 12-bit field that fills bits 15:4. The 4-bit immediate is sign-extended for arithmetic operations and zero-extended for logical ones. Decode picks the extension with a separate input.

A 16-bit constant does not fit in one instruction, so the block supports a two-instruction form. Decode pulses a prefix strobe for an instruction with opcode 0xD (instruction bits 15:12). The block then holds that instruction's bits 11:0. The next instruction that uses a short immediate gets those held bits as operand bits 15:4 and its own bits 3:0 as the low nibble. The held value is used in place of sign or zero extension. A pending flag shows that a prefix is waiting. All state moves only on cycles where the clock enable is high, so the pipeline can stall.

Top module: `opnd_b_mux`

## Requirements
- R1: After the asynchronous reset, the pending flag is 0 and a short immediate is extended normally.
- R2: With select 0 (register), the operand equals the register-read input, whether or not a prefix is pending.
- R3: With select 1 (short), no prefix pending and arithmetic mode high, the operand is instruction bits 3:0 sign-extended from bit 3.
- R4: With select 1, no prefix pending and arithmetic mode low, the operand is instruction bits 3:0 zero-extended.
- R5: With select 2 (upper), the operand is instruction bits 11:0 followed by four zero bits.
- R6: An enabled cycle with the prefix strobe high and no interrupt acknowledge stores instruction bits 11:0 and sets the pending flag for the next cycle.
- R7: With a prefix pending and select 1, the operand is the stored 12 bits above instruction bits 3:0, and the arithmetic mode has no effect.
- R8: The pending flag clears after exactly one enabled cycle without the prefix strobe.
- R9: A prefix strobe while a prefix is pending replaces the stored bits and keeps the flag set.
- R10: When the clock enable is low, neither the flag nor the stored bits change, even if the strobe is high.
- R11: An enabled cycle with interrupt acknowledge high clears the pending flag, and takes priority over a prefix strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable (stall when low) |
| insn_i | input | 16 | Current instruction word |
| reg_b_i | input | 16 | Register-file read value |
| sel_i | input | 2 | Operand source: 0 register, 1 short immediate, 2 upper field |
| arith_i | input | 1 | 1 sign-extends, 0 zero-extends the short immediate |
| prefix_i | input | 1 | Decode strobe for an immediate-prefix instruction |
| int_ack_i | input | 1 | Interrupt acknowledge; drops a pending prefix |
| opnd_b_o | output | 16 | Formed B operand |
| pfx_pending_o | output | 1 | A prefix is waiting to be consumed |

## Verification
The bench builds the block with its default widths: a 16-bit operand and a 4-bit short immediate, which leaves a 12-bit prefix field. With these widths the exact bit split can be checked. One case is a sign bit in the low nibble that must not spread under a pending prefix. Another is the top four bits of the upper field, which drop out into bit positions 15:12. With the default split, the instruction values in the checks map directly to hand-computed operands.

// File: rtl/opb_pkg.sv
package opb_pkg;
  typedef enum logic [1:0] {
    OPB_REG   = 2'd0,
    OPB_SHORT = 2'd1,
    OPB_UPPER = 2'd2
  } opb_sel_e;
endpackage

// File: rtl/imm_prefix_reg.sv
module imm_prefix_reg #(
  parameter int PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             ack_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             pending_o,
  output logic [PRE_W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      hold_o    <= '0;
    end else if (en_i) begin
      if (ack_i) begin
        pending_o <= 1'b0;
      end else if (load_i) begin
        pending_o <= 1'b1;
        hold_o    <= pre_i;
      end else begin
        pending_o <= 1'b0;  // one consumer only
      end
    end
  end
endmodule

// File: rtl/imm_short_ext.sv
module imm_short_ext #(
  parameter int DATA_W = 16,
  parameter int LO_W   = 4
) (
  input  logic [LO_W-1:0]   lo_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int HI_W = DATA_W - LO_W;
  logic fill;
  assign fill  = arith_i & lo_i[LO_W-1];
  assign ext_o = {{HI_W{fill}}, lo_i};
endmodule

// File: rtl/opnd_b_mux.sv
module opnd_b_mux #(
  parameter int DATA_W = 16,
  parameter int LO_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] insn_i,
  input  logic [DATA_W-1:0] reg_b_i,
  input  logic [1:0]        sel_i,
  input  logic              arith_i,
  input  logic              prefix_i,
  input  logic              int_ack_i,
  output logic [DATA_W-1:0] opnd_b_o,
  output logic              pfx_pending_o
);
  import opb_pkg::*;
  localparam int PRE_W = DATA_W - LO_W;

  logic [PRE_W-1:0]  pre_hold;
  logic [DATA_W-1:0] short_ext;
  logic [DATA_W-1:0] short_val;
  logic [DATA_W-1:0] upper_val;
  opb_sel_e          sel;

  imm_prefix_reg #(.PRE_W(PRE_W)) u_pfx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .load_i    (prefix_i),
    .ack_i     (int_ack_i),
    .pre_i     (insn_i[PRE_W-1:0]),
    .pending_o (pfx_pending_o),
    .hold_o    (pre_hold)
  );

  imm_short_ext #(.DATA_W(DATA_W), .LO_W(LO_W)) u_ext (
    .lo_i    (insn_i[LO_W-1:0]),
    .arith_i (arith_i),
    .ext_o   (short_ext)
  );

  // prefix replaces extension bits
  assign short_val = pfx_pending_o ? {pre_hold, insn_i[LO_W-1:0]} : short_ext;
  assign upper_val = {insn_i[PRE_W-1:0], {LO_W{1'b0}}};

  always_comb begin
    sel = opb_sel_e'(sel_i);
    unique case (sel)
      OPB_SHORT: opnd_b_o = short_val;
      OPB_UPPER: opnd_b_o = upper_val;
      default:   opnd_b_o = reg_b_i;
    endcase
  end
endmodule

// File: rtl/opnd_b_mux_chk.sv
module opnd_b_mux_chk #(
  parameter int DATA_W = 16,
  parameter int LO_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DATA_W-1:0] insn_i,
  input logic [DATA_W-1:0] reg_b_i,
  input logic [1:0]        sel_i,
  input logic              prefix_i,
  input logic              int_ack_i,
  input logic [DATA_W-1:0] opnd_b_o,
  input logic              pfx_pending_o
);
  default clocking cb @(posedge clk_i); endclocking

  a_r2_reg_pass: assert property (disable iff (!rst_ni)
    sel_i == 2'd0 |-> opnd_b_o == reg_b_i);
  a_r6_prefix_sets: assert property (disable iff (!rst_ni)
    en_i && prefix_i && !int_ack_i |=> pfx_pending_o);
  a_r7_low_nibble: assert property (disable iff (!rst_ni)
    pfx_pending_o && sel_i == 2'd1 |-> opnd_b_o[LO_W-1:0] == insn_i[LO_W-1:0]);
  a_r8_single_use: assert property (disable iff (!rst_ni)
    en_i && !prefix_i |=> !pfx_pending_o);
  a_r10_stall_hold: assert property (disable iff (!rst_ni)
    !en_i |=> $stable(pfx_pending_o));
  a_r11_ack_clears: assert property (disable iff (!rst_ni)
    en_i && int_ack_i |=> !pfx_pending_o);
endmodule

bind opnd_b_mux opnd_b_mux_chk #(.DATA_W(DATA_W), .LO_W(LO_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .insn_i        (insn_i),
  .reg_b_i       (reg_b_i),
  .sel_i         (sel_i),
  .prefix_i      (prefix_i),
  .int_ack_i     (int_ack_i),
  .opnd_b_o      (opnd_b_o),
  .pfx_pending_o (pfx_pending_o)
);

// File: tb/test_opnd_b_mux.sv
module test_opnd_b_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] insn = '0;
  logic [15:0] reg_b = '0;
  logic [1:0]  sel = 2'd0;
  logic        arith = 1'b0;
  logic        prefix = 1'b0;
  logic        int_ack = 1'b0;
  logic [15:0] opnd_b;
  logic        pending;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opnd_b_mux i_opnd_b_mux (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .insn_i(insn), .reg_b_i(reg_b),
    .sel_i(sel), .arith_i(arith), .prefix_i(prefix), .int_ack_i(int_ack),
    .opnd_b_o(opnd_b), .pfx_pending_o(pending)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic e, logic [15:0] i, logic [1:0] s, logic a, logic p, logic k);
    en = e; insn = i; sel = s; arith = a; prefix = p; int_ack = k;
    #1;
  endtask

  task automatic t_reset();
    drive(1'b1, 16'h200F, 2'd1, 1'b1, 1'b0, 1'b0);
    check("R1 pending", {15'b0, pending}, 16'h0000);
    check("R1 ext", opnd_b, 16'hFFFF);
  endtask

  task automatic t_reg();
    reg_b = 16'hA5C3;
    drive(1'b1, 16'h0123, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R2", opnd_b, 16'hA5C3);
  endtask

  task automatic t_short();
    drive(1'b1, 16'h2312, 2'd1, 1'b1, 1'b0, 1'b0);
    check("R3 pos", opnd_b, 16'h0002);
    drive(1'b1, 16'h231A, 2'd1, 1'b1, 1'b0, 1'b0);
    check("R3 neg", opnd_b, 16'hFFFA);
    drive(1'b1, 16'h231A, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R4", opnd_b, 16'h000A);
  endtask

  task automatic t_upper();
    drive(1'b1, 16'hC123, 2'd2, 1'b1, 1'b0, 1'b0);
    check("R5", opnd_b, 16'h1230);
    drive(1'b1, 16'hDFED, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R5 top", opnd_b, 16'hFED0);
  endtask

  task automatic t_prefix();
    drive(1'b1, 16'hDABC, 2'd0, 1'b0, 1'b1, 1'b0);
    step();
    check("R6 pending", {15'b0, pending}, 16'h0001);
    drive(1'b1, 16'h231F, 2'd1, 1'b1, 1'b0, 1'b0);
    check("R7 arith", opnd_b, 16'hABCF);
    drive(1'b1, 16'h231F, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R7 logic", opnd_b, 16'hABCF);
    reg_b = 16'h5A5A;
    drive(1'b1, 16'h031F, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R2 pending", opnd_b, 16'h5A5A);
    drive(1'b1, 16'h231F, 2'd1, 1'b1, 1'b0, 1'b0);
    step();
    check("R8 cleared", {15'b0, pending}, 16'h0000);
    check("R8 ext", opnd_b, 16'hFFFF);
  endtask

  task automatic t_replace();
    drive(1'b1, 16'hD111, 2'd0, 1'b0, 1'b1, 1'b0);
    step();
    drive(1'b1, 16'hD222, 2'd0, 1'b0, 1'b1, 1'b0);
    step();
    check("R9 pending", {15'b0, pending}, 16'h0001);
    drive(1'b1, 16'h2305, 2'd1, 1'b1, 1'b0, 1'b0);
    check("R9 value", opnd_b, 16'h2225);
    step();
    check("R8 after replace", {15'b0, pending}, 16'h0000);
  endtask

  task automatic t_stall();
    drive(1'b1, 16'hD7E4, 2'd0, 1'b0, 1'b1, 1'b0);
    step();
    drive(1'b0, 16'h2301, 2'd1, 1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 3; n++) step();
    check("R10 pending", {15'b0, pending}, 16'h0001);
    check("R10 value", opnd_b, 16'h7E41);
    drive(1'b0, 16'hD999, 2'd0, 1'b0, 1'b1, 1'b0);
    step();
    drive(1'b0, 16'h2303, 2'd1, 1'b1, 1'b0, 1'b0);
    check("R10 no load", opnd_b, 16'h7E43);
    drive(1'b1, 16'h2303, 2'd1, 1'b1, 1'b0, 1'b0);
    step();
    check("R10 resume", {15'b0, pending}, 16'h0000);
  endtask

  task automatic t_ack();
    drive(1'b1, 16'hD456, 2'd0, 1'b0, 1'b1, 1'b0);
    step();
    drive(1'b1, 16'hD789, 2'd0, 1'b0, 1'b1, 1'b1);
    step();
    check("R11 pending", {15'b0, pending}, 16'h0000);
    drive(1'b1, 16'h2309, 2'd1, 1'b1, 1'b0, 1'b0);
    check("R11 ext", opnd_b, 16'hFFF9);
  endtask

  initial begin
    #3 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reg();
    t_short();
    t_upper();
    t_prefix();
    t_replace();
    t_stall();
    t_ack();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule